// File: doc/BRIEF.md
# Decode-Stage Branch and Jump Resolver

This block settles control transfers in the decode stage of a five-stage pipeline. Each cycle it takes the decoded instruction's opcode, its function field, its low 26 instruction bits, the instruction's own address, and both register operands as they stand after forwarding. From these it computes four results: whether the PC must be redirected, the address to redirect to, whether register 31 must receive a return address, and the value of that address.

Every branch and jump has exactly one architectural delay slot, and that slot always executes. The resolver therefore never squashes the instruction behind a transfer. Instead it sets a registered flag that tells the next decode cycle it is handling a delay-slot instruction. A conditional branch that is not taken lets the PC keep stepping sequentially past the slot.

The PC register, instruction fetch and exception redirection sit outside this block. The surrounding pipeline feeds `taken_o`/`target_o` into its next-PC selection and routes `link_we_o`/`link_data_o` to the register-file write path for register 31.

Top module: `xfer_resolve`

## Requirements
- R1: For opcode 000100 (branch-if-equal), `taken_o` is 1 exactly when `opa_i == opb_i`. When taken, `target_o` = `pc_i` + 4 + (sign-extended `field_i[15:0]` shifted left by 2). The outputs follow the operand inputs within the same cycle.
- R2: For opcode 000101 (branch-if-not-equal), `taken_o` is 1 exactly when `opa_i != opb_i`. The target is computed as in R1.
- R3: A not-taken conditional branch drives `taken_o` = 0, so execution continues sequentially after the delay slot.
- R4: For opcode 000010 (direct jump), `taken_o` = 1 and `target_o` = {(`pc_i`+4)[31:28], `field_i[25:0]`, 2'b00}.
- R5: For opcode 000011 (jump-and-link), `taken_o` = 1 and the target is formed as in R4. In addition, `link_we_o` = 1 and `link_data_o` = `pc_i` + 8.
- R6: For opcode 000000 with `fn_i` = 001000 (register-indirect jump), `taken_o` = 1 and `target_o` = `opa_i`.
- R7: Any other opcode, or opcode 000000 with any other function value, drives `taken_o` = 0 and `link_we_o` = 0.
- R8: `slot_o` is 0 after reset. In the cycle after a clock edge, `slot_o` is 1 exactly when the instruction presented before that edge was one of the five transfers in R1, R2, R4, R5 and R6, whether or not it was taken.
- R9: `link_we_o` is 1 only for jump-and-link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 6 | Opcode of the decoded instruction |
| fn_i | input | 6 | Function field of the decoded instruction |
| field_i | input | 26 | Low 26 instruction bits: the jump index, with the branch offset in bits 15:0 |
| pc_i | input | 32 | Address of the decoded instruction |
| opa_i | input | 32 | First register operand (rs), after forwarding |
| opb_i | input | 32 | Second register operand (rt), after forwarding |
| taken_o | output | 1 | Redirect the PC after the delay slot |
| target_o | output | 32 | Redirect address |
| link_we_o | output | 1 | Write the return address to register 31 |
| link_data_o | output | 32 | Return address |
| slot_o | output | 1 | Current decode instruction is in a delay slot |

## Verification
Several relations are checked by assertions on every cycle:
- a taken redirect only arises from a transfer opcode;
- jumps and register-indirect jumps are always taken;
- link writes occur only for jump-and-link, and carry PC+8;
- a transfer is always followed by a raised delay-slot flag.

Other behaviour can only be shown by the bench's scenarios with computed expectations. This covers the exact branch-target arithmetic, including negative offsets. It also covers the jump-region bits taken from PC+4 when PC+4 crosses a 256 MB boundary, and the equal/not-equal decisions on forwarded operands.

// File: rtl/xfer_resolve.sv
module xfer_resolve #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [5:0]   op_i,
  input  logic [5:0]   fn_i,
  input  logic [25:0]  field_i,
  input  logic [W-1:0] pc_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  output logic         taken_o,
  output logic [W-1:0] target_o,
  output logic         link_we_o,
  output logic [W-1:0] link_data_o,
  output logic         slot_o
);
  localparam logic [5:0] OP_REG = 6'b000000;
  localparam logic [5:0] OP_J   = 6'b000010;
  localparam logic [5:0] OP_JAL = 6'b000011;
  localparam logic [5:0] OP_BEQ = 6'b000100;
  localparam logic [5:0] OP_BNE = 6'b000101;
  localparam logic [5:0] FN_JR  = 6'b001000;
  localparam int         SEXT   = W - 18;

  logic [W-1:0] seq4, br_tgt, jmp_tgt;
  logic         same, is_xfer;

  assign seq4        = pc_i + W'(4);
  assign br_tgt      = seq4 + {{SEXT{field_i[15]}}, field_i[15:0], 2'b00};
  assign jmp_tgt     = {seq4[W-1:28], field_i, 2'b00};
  assign same        = (opa_i == opb_i);
  assign link_we_o   = (op_i == OP_JAL);
  assign link_data_o = pc_i + W'(8);

  always_comb begin
    taken_o  = 1'b0;
    target_o = br_tgt;
    is_xfer  = 1'b1;
    case (op_i)
      OP_BEQ: taken_o = same;
      OP_BNE: taken_o = !same;
      OP_J, OP_JAL: begin
        taken_o  = 1'b1;
        target_o = jmp_tgt;
      end
      OP_REG: begin
        taken_o  = (fn_i == FN_JR);
        is_xfer  = (fn_i == FN_JR);
        target_o = opa_i;
      end
      default: is_xfer = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) slot_o <= 1'b0;
    else        slot_o <= is_xfer;
endmodule

// File: rtl/xfer_resolve_chk.sv
module xfer_resolve_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [5:0]   op_i,
  input logic [5:0]   fn_i,
  input logic [W-1:0] pc_i,
  input logic [W-1:0] opa_i,
  input logic         taken_o,
  input logic [W-1:0] target_o,
  input logic         link_we_o,
  input logic [W-1:0] link_data_o,
  input logic         slot_o
);
  logic jr_op, any_xfer;
  assign jr_op    = (op_i == 6'b000000) && (fn_i == 6'b001000);
  assign any_xfer = jr_op || (op_i inside {6'b000010, 6'b000011, 6'b000100, 6'b000101});

  a_r7_taken_needs_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> any_xfer);
  a_r4_jump_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 6'b000010) |-> taken_o);
  a_r6_jr_target: assert property (@(posedge clk) disable iff (!rst_n)
    jr_op |-> (taken_o && target_o == opa_i));
  a_r9_link_only_jal: assert property (@(posedge clk) disable iff (!rst_n)
    link_we_o |-> (op_i == 6'b000011));
  a_r5_link_value: assert property (@(posedge clk) disable iff (!rst_n)
    link_we_o |-> (link_data_o == pc_i + W'(8) && taken_o));
  a_r8_slot_follows: assert property (@(posedge clk) disable iff (!rst_n)
    any_xfer |=> slot_o);
  a_r8_no_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !any_xfer |=> !slot_o);
endmodule

bind xfer_resolve xfer_resolve_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .op_i(op_i), .fn_i(fn_i), .pc_i(pc_i),
  .opa_i(opa_i), .taken_o(taken_o), .target_o(target_o),
  .link_we_o(link_we_o), .link_data_o(link_data_o), .slot_o(slot_o)
);

// File: tb/xfer_resolve_tb_top.sv
module xfer_resolve_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [5:0]  op_i = '0, fn_i = '0;
  logic [25:0] field_i = '0;
  logic [31:0] pc_i = '0, opa_i = '0, opb_i = '0;
  logic        taken_o, link_we_o, slot_o;
  logic [31:0] target_o, link_data_o;
  int          n_chk = 0, n_bad = 0;
  bit          exp_slot = 1'b0;

  always #10 clk = ~clk;

  xfer_resolve dut_i (.*);

  function automatic bit xfer_of(logic [5:0] op, logic [5:0] fn);
    return (op inside {6'd2, 6'd3, 6'd4, 6'd5}) || (op == 6'd0 && fn == 6'b001000);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [5:0] op, logic [5:0] fn, logic [25:0] fld,
                       logic [31:0] pc, logic [31:0] a, logic [31:0] b);
    logic [31:0] seq4;
    @(negedge clk);
    chk("R8 slot", {31'd0, slot_o}, {31'd0, exp_slot});
    op_i = op; fn_i = fn; field_i = fld; pc_i = pc; opa_i = a; opb_i = b;
    #1;
    seq4 = pc + 32'd4;
    case (op)
      6'd4: begin
        chk("R1 beq taken", {31'd0, taken_o}, {31'd0, a == b});
        if (a == b)
          chk("R1 beq target", target_o, seq4 + {{14{fld[15]}}, fld[15:0], 2'b00});
        else chk("R3 not taken", {31'd0, taken_o}, 32'd0);
      end
      6'd5: begin
        chk("R2 bne taken", {31'd0, taken_o}, {31'd0, a != b});
        if (a != b)
          chk("R2 bne target", target_o, seq4 + {{14{fld[15]}}, fld[15:0], 2'b00});
        else chk("R3 not taken", {31'd0, taken_o}, 32'd0);
      end
      6'd2, 6'd3: begin
        chk("R4 jump taken", {31'd0, taken_o}, 32'd1);
        chk("R4 jump target", target_o, {seq4[31:28], fld, 2'b00});
        if (op == 6'd3) chk("R5 link data", link_data_o, pc + 32'd8);
      end
      default:
        if (op == 6'd0 && fn == 6'b001000) begin
          chk("R6 jr taken", {31'd0, taken_o}, 32'd1);
          chk("R6 jr target", target_o, a);
        end else chk("R7 no transfer", {31'd0, taken_o}, 32'd0);
    endcase
    chk("R9 link we", {31'd0, link_we_o}, {31'd0, op == 6'd3});
    exp_slot = xfer_of(op, fn);
  endtask

  initial begin
    #15000000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [5:0] ops [8] = '{6'd0, 6'd2, 6'd3, 6'd4, 6'd5, 6'd8, 6'd13, 6'd35};
    logic [31:0] r;
    void'($urandom(32'd4242));
    #35;
    chk("R8 reset slot", {31'd0, slot_o}, 32'd0);
    rst_n = 1'b1;
    apply(6'd4, 6'd0, 26'h000FFFF, 32'h0000_1000, 32'h55, 32'h55);
    apply(6'd4, 6'd0, 26'h0000010, 32'h0000_1000, 32'h55, 32'h56);
    apply(6'd5, 6'd0, 26'h0008000, 32'h0040_0000, 32'h1, 32'h1);
    apply(6'd5, 6'd0, 26'h0008000, 32'h0040_0000, 32'h0, 32'h1);
    apply(6'd2, 6'd0, 26'h3FFFFFF, 32'h0FFF_FFFC, 32'h0, 32'h0);
    apply(6'd3, 6'd0, 26'h0000010, 32'hF000_0020, 32'h0, 32'h0);
    apply(6'd0, 6'b001000, 26'h0, 32'h100, 32'hDEAD_BEE0, 32'h0);
    apply(6'd0, 6'b100000, 26'h0, 32'h104, 32'h7, 32'h7);
    apply(6'd13, 6'd0, 26'h0, 32'h108, 32'h7, 32'h7);
    for (int i = 0; i < 400; i++) begin
      r = $urandom;
      apply(ops[r[2:0]], r[5] ? 6'b001000 : r[11:6], 26'($urandom), {$urandom & 32'hFFFF_FFFC},
            $urandom, r[4] ? 32'h1234 : $urandom);
    end
    @(negedge clk);
    chk("R8 slot", {31'd0, slot_o}, {31'd0, exp_slot});
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule